// File: doc/BRIEF.md
# Eight-to-one I/Q decimating FIR with bypass

This block sits in a receive path and turns a stream of complex samples into a slower stream. Each valid cycle brings one in-phase and one quadrature sample, both 16-bit signed. The two samples go into two separate 128-tap histories. When decimation is on, one filtered I/Q pair comes out for every eight accepted samples. Each channel's result is a full-precision dot product with 18-bit coefficients. That result is rounded and saturated back to 16 bits. When decimation is off, each accepted pair is forwarded unchanged. In both modes the output is one 32-bit word with a single-cycle valid pulse.

The mode is tracked by a two-state machine. `ST_PASS` forwards every sample. `ST_DECIM` counts accepted samples with a phase counter. There are four transitions:
- `PASS->DECIM` when `decim_en` is seen high.
- `DECIM->PASS` when `decim_en` is seen low.
- `PASS->PASS` and `DECIM->DECIM` as self-loops while the control bit stays the same.

In any cycle where the control bit disagrees with the current state, the machine treats the phase as zero. That cycle counts as the start of a new group of eight. The coefficient set is symmetric, in Q1.17, and computed by a closed-form function, so no table is stored.

Top module: `fir8_decim_iq`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_data` is 0, both sample histories hold zeros, the phase is 0 and the state is `ST_PASS`.
- R2: `out_valid` is high for one cycle only, in the cycle after the clock edge that accepted the causing input. It is never high unless `in_valid` was high in the previous cycle.
- R3: With `decim_en` = 1, exactly one filtered output is produced per eight accepted samples. Cycles with `in_valid` = 0 do not advance the phase.
- R4: A filtered output per channel is y = sum over k=0..127 of h[k]·x[n−k], where x[n] is the sample accepted in the emitting cycle. h[k] = floor(3·i²/4) with i = min(k, 127−k) + 1, read as Q1.17.
- R5: With `decim_en` = 0, every accepted pair appears on the next cycle as `out_data` = {Q, I}: I in bits 15:0 and Q in bits 31:16. Filtered words use the same packing.
- R6: I and Q are filtered independently. A sample on one channel never affects the other channel's result.
- R7: Rounding adds 2^16 to the full-precision sum, then shifts it arithmetically right by 17. Exact halves therefore round toward positive infinity.
- R8: A rounded result above 32767 or below −32768 is clamped to that limit.
- R9: Any change of `decim_en`, with or without a valid sample, restarts the phase. The first filtered output comes on the eighth accepted sample, counted from and including the first cycle with `decim_en` = 1.
- R10: Both histories take in accepted samples in both modes. A filtered output right after a switch uses samples accepted while in bypass.
- R11: Between pulses, `out_data` holds the last word it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decim_en | input | 1 | 1 = decimate by 8, 0 = forward every sample |
| in_valid | input | 1 | Qualifies `in_i` and `in_q` |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Single-cycle output strobe |
| out_data | output | 32 | {Q, I} result word |

## Verification
A wrong phase count or a missed phase restart shows up at the first filtered pulse after the fault. That pulse arrives one or more accepted samples early or late, and within at most eight accepted samples the pulse train drifts away from the expected eight-sample spacing. A corrupted history tap does not show in bypass at all. It shows only in filtered words, and it stays visible for up to 128 accepted samples, until the bad value shifts out. A rounding or clamping fault shows only on results near a half step or near full scale. For that reason, a rounding case with a known exact half and sustained full-scale inputs are driven on purpose.

// File: rtl/fir8_pkg.sv
package fir8_pkg;
    localparam int SAMP_W = 16;
    localparam int COEF_W = 18;
    localparam int FRAC_W = 17;

    typedef logic signed [SAMP_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic [0:0] {
        ST_PASS  = 1'b0,
        ST_DECIM = 1'b1
    } mode_state_t;

    // symmetric low-pass taps in Q1.17, derived from the tap index
    function automatic coef_t tap_coef(input int k, input int taps);
        int i;
        i = (k < taps / 2) ? (k + 1) : (taps - k);
        return coef_t'((3 * i * i) / 4);
    endfunction
endpackage

// File: rtl/fir8_phase_ctrl.sv
module fir8_phase_ctrl
    import fir8_pkg::*;
#(
    parameter int DECIM = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic decim_en,
    input  logic in_valid,
    output logic emit_filt,
    output logic emit_pass
);
    localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [PW-1:0] LAST = PW'(DECIM - 1);

    mode_state_t state, state_nx;
    logic [PW-1:0] phase, phase_nx, phase_eff;
    logic          mode_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PASS;
            phase <= '0;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    always_comb begin
        mode_match = (decim_en == (state == ST_DECIM));
        phase_eff  = mode_match ? phase : '0;
        state_nx   = state;
        phase_nx   = phase_eff;
        emit_filt  = 1'b0;
        emit_pass  = 1'b0;
        unique case (state)
            ST_PASS: begin
                if (decim_en) state_nx = ST_DECIM;
            end
            ST_DECIM: begin
                if (!decim_en) state_nx = ST_PASS;
            end
            default: state_nx = ST_PASS;
        endcase
        if (in_valid && decim_en) begin
            emit_filt = (phase_eff == LAST);
            phase_nx  = (phase_eff == LAST) ? '0 : phase_eff + 1'b1;
        end
        if (in_valid && !decim_en) emit_pass = 1'b1;
    end

    a_r3_phase_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && decim_en && state == ST_DECIM) |=> (phase == $past(phase)));

    a_r9_switch_restarts: assert property (@(posedge clk) disable iff (rst)
        (decim_en && state == ST_PASS) |=>
            (state == ST_DECIM && phase == ($past(in_valid) ? PW'(1) : PW'(0))));

    a_r3_one_emit_kind: assert property (@(posedge clk) disable iff (rst)
        !(emit_filt && emit_pass));
endmodule

// File: rtl/fir8_tap_line.sv
module fir8_tap_line
    import fir8_pkg::*;
#(
    parameter int TAPS = 128
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift,
    input  sample_t din,
    output sample_t line_nx [TAPS]
);
    sample_t line_q [TAPS];

    assign line_nx[0] = din;

    generate
        for (genvar t = 0; t < TAPS; t++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst)        line_q[t] <= '0;
                else if (shift) line_q[t] <= line_nx[t];
            end
            if (t > 0) begin : g_link
                assign line_nx[t] = line_q[t-1];
            end
        end
    endgenerate

    a_r10_line_holds: assert property (@(posedge clk) disable iff (rst)
        !shift |=> ($stable(line_q[0]) && $stable(line_q[TAPS-1])));

    a_r10_line_takes: assert property (@(posedge clk) disable iff (rst)
        shift |=> (line_q[0] == $past(din)));
endmodule

// File: rtl/fir8_dot.sv
module fir8_dot
    import fir8_pkg::*;
#(
    parameter int TAPS = 128
) (
    input  sample_t taps_in [TAPS],
    output sample_t y
);
    localparam int ACC_W = SAMP_W + COEF_W + $clog2(TAPS);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);

    logic signed [ACC_W-1:0] acc, rnd, shr;

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + (ACC_W'(taps_in[k]) * ACC_W'(tap_coef(k, TAPS)));
        end
        rnd = acc + HALF;
        shr = rnd >>> FRAC_W;
        if (shr > MAXV)      y = sample_t'(MAXV);
        else if (shr < MINV) y = sample_t'(MINV);
        else                 y = sample_t'(shr);
    end
endmodule

// File: rtl/fir8_decim_iq.sv
module fir8_decim_iq
    import fir8_pkg::*;
#(
    parameter int TAPS  = 128,
    parameter int DECIM = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        decim_en,
    input  logic        in_valid,
    input  logic [15:0] in_i,
    input  logic [15:0] in_q,
    output logic        out_valid,
    output logic [31:0] out_data
);
    localparam int NCH = 2;

    logic emit_filt, emit_pass;
    logic [NCH*SAMP_W-1:0] filt_word;
    logic [NCH*SAMP_W-1:0] raw_word;

    assign raw_word = {in_q, in_i};

    fir8_phase_ctrl #(.DECIM(DECIM)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .decim_en (decim_en),
        .in_valid (in_valid),
        .emit_filt(emit_filt),
        .emit_pass(emit_pass)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            sample_t line_nx [TAPS];
            sample_t y;

            fir8_tap_line #(.TAPS(TAPS)) u_line (
                .clk    (clk),
                .rst    (rst),
                .shift  (in_valid),
                .din    (sample_t'(raw_word[c*SAMP_W +: SAMP_W])),
                .line_nx(line_nx)
            );

            fir8_dot #(.TAPS(TAPS)) u_dot (
                .taps_in(line_nx),
                .y      (y)
            );

            assign filt_word[c*SAMP_W +: SAMP_W] = y;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit_filt | emit_pass;
            if (emit_pass)      out_data <= raw_word;
            else if (emit_filt) out_data <= filt_word;
        end
    end

    a_r2_pulse_source: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r5_bypass_forward: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !decim_en) |=> (out_valid && out_data == $past({in_q, in_i})));

    a_r11_hold_word: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

// File: tb/test_fir8_decim_iq.sv
`timescale 1ns/1ps
module test_fir8_decim_iq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        decim_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;

    int  hist_i [128];
    int  hist_q [128];
    int  m_phase;
    bit  m_mode;
    bit  exp_valid;
    logic [31:0] exp_data;

    always #2 clk = ~clk;

    fir8_decim_iq i_fir8_decim_iq (
        .clk(clk), .rst(rst), .decim_en(decim_en), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int coefb(int k);
        int i;
        i = (k < 64) ? k + 1 : 128 - k;
        return (3 * i * i) / 4;
    endfunction

    function automatic logic [15:0] model_out(bit use_q);
        longint acc = 0;
        for (int k = 0; k < 128; k++)
            acc += longint'(use_q ? hist_q[k] : hist_i[k]) * longint'(coefb(k));
        acc = (acc + 65536) >>> 17;
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return 16'(acc);
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic model_step(bit v, logic [15:0] si, logic [15:0] sq, bit d);
        int eff;
        eff = (d == m_mode) ? m_phase : 0;
        exp_valid = 1'b0;
        if (v) begin
            for (int k = 127; k > 0; k--) begin
                hist_i[k] = hist_i[k-1];
                hist_q[k] = hist_q[k-1];
            end
            hist_i[0] = int'($signed(si));
            hist_q[0] = int'($signed(sq));
            if (d) begin
                if (eff == 7) begin
                    exp_valid = 1'b1;
                    exp_data  = {model_out(1'b1), model_out(1'b0)};
                end
                eff = (eff + 1) % 8;
            end else begin
                exp_valid = 1'b1;
                exp_data  = {sq, si};
            end
        end
        m_phase = eff;
        m_mode  = d;
    endtask

    task automatic step(bit v, logic [15:0] si, logic [15:0] sq, bit d, string tag);
        @(negedge clk);
        in_valid = v; in_i = si; in_q = sq; decim_en = d;
        @(posedge clk);
        #1;
        model_step(v, si, sq, d);
        check(out_valid == exp_valid, tag, "out_valid", 32'(out_valid), 32'(exp_valid));
        check(out_data == exp_data, exp_valid ? tag : "R11", "out_data", out_data, exp_data);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; decim_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        for (int k = 0; k < 128; k++) begin hist_i[k] = 0; hist_q[k] = 0; end
        m_phase = 0; m_mode = 1'b0; exp_valid = 1'b0; exp_data = '0;
        // R1: reset state at the ports
        check(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'h0);
        check(out_data == 32'h0, "R1", "out_data", out_data, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R5 bypass with extremes and gaps (R2)
        step(1, 16'h7FFF, 16'h8000, 0, "R5");
        step(0, 16'h1234, 16'h5678, 0, "R2");
        step(1, 16'h8000, 16'h7FFF, 0, "R5");
        step(1, 16'h0001, 16'hFFFF, 0, "R5");
        step(0, 16'h0000, 16'h0000, 0, "R2");

        // R4 / R6 impulse on I only, then on Q only
        do_reset();
        step(1, 16'd1000, 16'd0, 1, "R4");
        for (int n = 0; n < 140; n++) step(1, 16'd0, 16'd0, 1, "R6");
        step(1, 16'd0, 16'hF000, 1, "R6");
        for (int n = 0; n < 140; n++) step((n % 3) != 1, 16'd0, 16'd0, 1, "R3");

        // R7 exact half: 4096*48/2^17 = 1.5 -> 2, -1.5 -> -1
        do_reset();
        step(1, 16'd4096, 16'hF000, 1, "R7");
        for (int n = 0; n < 7; n++) step(1, 16'd0, 16'd0, 1, "R7");
        check(out_data == {16'hFFFF, 16'h0002}, "R7", "rounded pair", out_data, {16'hFFFF, 16'h0002});

        // R8 sustained full scale saturates
        do_reset();
        for (int n = 0; n < 136; n++) step(1, 16'h7FFF, 16'h8000, 1, "R8");
        check(out_data == {16'h8000, 16'h7FFF}, "R8", "clamped pair", out_data, {16'h8000, 16'h7FFF});

        // R9 phase restart on control change; R10 history from bypass
        do_reset();
        for (int n = 0; n < 130; n++) step(1, 16'(n * 37), 16'(-n * 11), 0, "R10");
        for (int n = 0; n < 3; n++) step(1, 16'd500, 16'd700, 1, "R9");
        step(0, 16'd0, 16'd0, 0, "R9");
        for (int n = 0; n < 8; n++) step(1, 16'(n * 100), 16'd300, 1, "R9");
        step(1, 16'd9, 16'd9, 1, "R9");

        // constrained random with occasional mode changes
        begin
            bit md = 1'b1;
            for (int n = 0; n < 4000; n++) begin
                if ((n % 300) == 0) md = 1'($urandom % 2);
                if (($urandom % 100) == 0) md = ~md;
                step(($urandom % 10) < 6, 16'($urandom), 16'($urandom), md,
                     md ? "R3" : "R5");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule